// File: doc/BRIEF.md
# Interrupting Input Peripheral

This block is a small peripheral attached to a simple processor bus. An external source hands it a byte together with a one-cycle strobe. The peripheral latches the byte and raises an interrupt request. The processor services the request by reading the byte through the bus. That read is also what withdraws the request. A second register receives the processed result from the processor and announces each new value with a one-cycle valid pulse. A third address reports a sticky overrun flag and the pending state of the request.

The block also carries a small model of the processor's fixed-vector behaviour, so the whole service loop can be exercised from one top level. The model works as follows:
- It samples the request only when an instruction completes.
- When it takes the request, it records the program counter and jumps to a fixed handler address.
- When the handler returns, it resumes one location past the recorded value.
- It does not nest: a request seen while the handler runs is not taken.

Top module: `intr_input_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the following outputs are zero: irq, bus_rdata, out_data, out_valid and cpu_in_isr. cpu_pc equals RESET_PC (default 100).
- R2: A cycle with ext_stb high loads ext_data into the input register, and irq is high from the next cycle on.
- R3: A read of address 0x8000 (bus_sel high, bus_we low) places the input register's value on bus_rdata in the next cycle. If no new byte arrives in the same cycle, irq is low in that next cycle.
- R4: When a read of 0x8000 and ext_stb fall in the same cycle, the read returns the older byte, the new byte is stored, and irq stays high.
- R5: A byte arriving while irq is high, with no read of 0x8000 in the same cycle, replaces the stored byte and sets a sticky overrun flag. A read of 0x8002 returns bit 0 = overrun and bit 1 = irq, with all other bits zero. That read clears the overrun flag, unless another overrun occurs in the same cycle.
- R6: A write to 0x8001 (bus_sel and bus_we high) puts bus_wdata on out_data in the next cycle, and out_valid is high for exactly that one cycle. A read of 0x8001 returns out_data.
- R7: Reads of any address other than 0x8000, 0x8001 and 0x8002 return zero. bus_rdata is zero in every cycle that does not follow a read. A write to any address other than 0x8001 changes no register.
- R8: When cpu_step is high, cpu_in_isr is low and irq is high, cpu_pc becomes HANDLER_VEC (default 16) and cpu_in_isr becomes high. Any other cpu_step advances cpu_pc by one. While cpu_in_isr is high the request is never taken again.
- R9: cpu_ret while cpu_in_isr is high sets cpu_pc to the recorded value plus one and clears cpu_in_isr, and it takes priority over a cpu_step in the same cycle. cpu_ret while cpu_in_isr is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| ext_stb | input | 1 | New byte from the external source |
| ext_data | input | 8 | Byte from the external source |
| irq | output | 1 | Interrupt request |
| out_data | output | 8 | Processed-output register |
| out_valid | output | 1 | One-cycle pulse after each output write |
| cpu_step | input | 1 | An instruction completes this cycle |
| cpu_ret | input | 1 | A handler return completes this cycle |
| cpu_pc | output | 16 | Modelled program counter |
| cpu_in_isr | output | 1 | Handler is running |

## Verification
The properties assume that each bus strobe lasts exactly one cycle and carries a single address. They also assume that cpu_ret is raised only at instruction boundaries, like cpu_step, so that the two can be weighed against each other in the same cycle. The stimulus follows these rules by driving every input for one clock from a task and returning it to idle. The random phase draws addresses only from the three register locations and one unmapped location, so every access kind is covered without producing malformed strobes.

// File: rtl/intr_port_pkg.sv
`timescale 1ns/1ps
package intr_port_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PC_W   = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_IN,
        REG_OUT,
        REG_STAT
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e target;
        byte_t    wdata;
    } bus_op_t;

    typedef struct packed {
        logic irq;
        logic overrun;
    } in_flags_t;

    function automatic reg_sel_e map_addr(addr_t a, addr_t in_a, addr_t out_a, addr_t stat_a);
        if (a == in_a)        return REG_IN;
        else if (a == out_a)  return REG_OUT;
        else if (a == stat_a) return REG_STAT;
        else                  return REG_NONE;
    endfunction

    function automatic byte_t status_byte(in_flags_t f);
        return {{(DATA_W-2){1'b0}}, f.irq, f.overrun};
    endfunction

endpackage

// File: rtl/intr_bus_decode.sv
`timescale 1ns/1ps
module intr_bus_decode
    import intr_port_pkg::*;
#(
    parameter addr_t IN_ADDR   = 16'h8000,
    parameter addr_t OUT_ADDR  = 16'h8001,
    parameter addr_t STAT_ADDR = 16'h8002
) (
    input  logic    sel,
    input  logic    we,
    input  addr_t   addr,
    input  byte_t   wdata,
    output bus_op_t op
);
    always_comb begin
        op.rd     = sel & ~we;
        op.wr     = sel & we;
        op.target = sel ? map_addr(addr, IN_ADDR, OUT_ADDR, STAT_ADDR) : REG_NONE;
        op.wdata  = wdata;
    end
endmodule

// File: rtl/intr_in_capture.sv
`timescale 1ns/1ps
module intr_in_capture
    import intr_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_stb,
    input  byte_t     ext_data,
    input  logic      take_in,
    input  logic      take_stat,
    output byte_t     data_q,
    output in_flags_t flags_q
);
    in_flags_t flags_n;
    logic      lost;

    always_comb begin
        lost            = ext_stb & flags_q.irq & ~take_in;
        flags_n.irq     = ext_stb | (flags_q.irq & ~take_in);
        if (lost)
            flags_n.overrun = 1'b1;
        else if (take_stat)
            flags_n.overrun = 1'b0;
        else
            flags_n.overrun = flags_q.overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= flags_n;
            if (ext_stb)
                data_q <= ext_data;
        end
    end
endmodule

// File: rtl/intr_out_reg.sv
`timescale 1ns/1ps
module intr_out_reg
    import intr_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t wdata,
    output byte_t out_q,
    output logic  valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load)
                out_q <= wdata;
        end
    end
endmodule

// File: rtl/intr_fixed_vector_seq.sv
`timescale 1ns/1ps
module intr_fixed_vector_seq
    import intr_port_pkg::*;
#(
    parameter pc_t HANDLER_VEC = 16,
    parameter pc_t RESET_PC    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic step,
    input  logic ret,
    output pc_t  pc_q,
    output logic in_isr_q
);
    pc_t saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            saved_q  <= '0;
            in_isr_q <= 1'b0;
        end else if (ret && in_isr_q) begin
            pc_q     <= saved_q + pc_t'(1);
            in_isr_q <= 1'b0;
        end else if (step) begin
            if (irq && !in_isr_q) begin
                saved_q  <= pc_q;
                pc_q     <= HANDLER_VEC;
                in_isr_q <= 1'b1;
            end else begin
                pc_q <= pc_q + pc_t'(1);
            end
        end
    end
endmodule

// File: rtl/intr_input_port.sv
`timescale 1ns/1ps
module intr_input_port
    import intr_port_pkg::*;
#(
    parameter addr_t IN_ADDR     = 16'h8000,
    parameter addr_t OUT_ADDR    = 16'h8001,
    parameter addr_t STAT_ADDR   = 16'h8002,
    parameter pc_t   HANDLER_VEC = 16,
    parameter pc_t   RESET_PC    = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_stb,
    input  logic [DATA_W-1:0] ext_data,
    output logic              irq,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              cpu_step,
    input  logic              cpu_ret,
    output logic [PC_W-1:0]   cpu_pc,
    output logic              cpu_in_isr
);
    bus_op_t   op;
    byte_t     in_q;
    byte_t     out_q;
    in_flags_t flags_q;
    byte_t     rdata_q;

    intr_bus_decode #(
        .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_dec (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .op(op)
    );

    intr_in_capture u_cap (
        .clk(clk), .rst(rst),
        .ext_stb(ext_stb), .ext_data(ext_data),
        .take_in(op.rd && op.target == REG_IN),
        .take_stat(op.rd && op.target == REG_STAT),
        .data_q(in_q), .flags_q(flags_q)
    );

    intr_out_reg u_out (
        .clk(clk), .rst(rst),
        .load(op.wr && op.target == REG_OUT),
        .wdata(op.wdata),
        .out_q(out_q), .valid_q(out_valid)
    );

    intr_fixed_vector_seq #(
        .HANDLER_VEC(HANDLER_VEC), .RESET_PC(RESET_PC)
    ) u_seq (
        .clk(clk), .rst(rst), .irq(flags_q.irq),
        .step(cpu_step), .ret(cpu_ret),
        .pc_q(cpu_pc), .in_isr_q(cpu_in_isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op.rd) begin
            unique case (op.target)
                REG_IN:   rdata_q <= in_q;
                REG_OUT:  rdata_q <= out_q;
                REG_STAT: rdata_q <= status_byte(flags_q);
                default:  rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = flags_q.irq;
    assign out_data  = out_q;
endmodule

// File: rtl/intr_input_port_chk.sv
`timescale 1ns/1ps
module intr_input_port_chk
    import intr_port_pkg::*;
#(
    parameter addr_t IN_ADDR     = 16'h8000,
    parameter addr_t OUT_ADDR    = 16'h8001,
    parameter pc_t   HANDLER_VEC = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ext_stb,
    input logic              irq,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              cpu_step,
    input logic              cpu_ret,
    input logic [PC_W-1:0]   cpu_pc,
    input logic              cpu_in_isr
);
    assert_irq_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ext_stb));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == IN_ADDR && !ext_stb) |=> !irq);

    assert_read_meets_arrival_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == IN_ADDR && ext_stb) |=> irq);

    assert_out_write_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == OUT_ADDR) |=> (out_valid && out_data == $past(bus_wdata)));

    assert_valid_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(bus_sel && bus_we && bus_addr == OUT_ADDR));

    assert_other_write_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr != OUT_ADDR) |=> ($stable(out_data) && !out_valid));

    assert_take_vector_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_step && irq && !cpu_in_isr) |=> (cpu_pc == HANDLER_VEC && cpu_in_isr));

    assert_plain_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_step && !irq && !(cpu_ret && cpu_in_isr)) |=> (cpu_pc == $past(cpu_pc) + 1'b1));

    assert_no_nesting_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_in_isr && !cpu_ret) |=> cpu_in_isr);

    assert_return_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_ret && cpu_in_isr) |=> !cpu_in_isr);

    assert_stray_return_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_ret && !cpu_in_isr && !cpu_step) |=> $stable(cpu_pc));
endmodule

bind intr_input_port intr_input_port_chk #(
    .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR), .HANDLER_VEC(HANDLER_VEC)
) chk_i (.*);

// File: tb/intr_input_port_test.sv
`timescale 1ns/1ps
module intr_input_port_test;
    localparam int IN_A = 16'h8000, OUT_A = 16'h8001, ST_A = 16'h8002, NONE_A = 16'h1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0, ext_data = '0;
    logic        ext_stb = 1'b0, cpu_step = 1'b0, cpu_ret = 1'b0;
    logic [7:0]  bus_rdata, out_data;
    logic        irq, out_valid, cpu_in_isr;
    logic [15:0] cpu_pc;

    int n_chk = 0, n_fail = 0;
    int m_data, m_irq, m_ovr, m_out, m_valid, m_rdata, m_pc, m_isr, m_saved;

    always #2.5 clk = ~clk;

    intr_input_port uut (.*);

    task automatic expect_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_data = 0; m_irq = 0; m_ovr = 0; m_out = 0; m_valid = 0;
        m_rdata = 0; m_pc = 100; m_isr = 0; m_saved = 0;
    endtask

    task automatic model_update();
        bit rd, wr, rd_in;
        int n_irq, n_ovr;
        rd    = bus_sel && !bus_we;
        wr    = bus_sel && bus_we;
        rd_in = rd && bus_addr == IN_A;
        m_rdata = 0;
        if (rd) begin
            if (bus_addr == IN_A)       m_rdata = m_data;
            else if (bus_addr == OUT_A) m_rdata = m_out;
            else if (bus_addr == ST_A)  m_rdata = m_irq * 2 + m_ovr;
        end
        n_ovr = m_ovr;
        if (ext_stb && m_irq && !rd_in) n_ovr = 1;
        else if (rd && bus_addr == ST_A) n_ovr = 0;
        n_irq = (ext_stb || (m_irq && !rd_in)) ? 1 : 0;
        if (cpu_ret && m_isr) begin
            m_pc = (m_saved + 1) & 16'hFFFF; m_isr = 0;
        end else if (cpu_step) begin
            if (m_irq && !m_isr) begin
                m_saved = m_pc; m_pc = 16; m_isr = 1;
            end else m_pc = (m_pc + 1) & 16'hFFFF;
        end
        if (ext_stb) m_data = ext_data;
        m_valid = (wr && bus_addr == OUT_A) ? 1 : 0;
        if (m_valid) m_out = bus_wdata;
        m_irq = n_irq; m_ovr = n_ovr;
    endtask

    task automatic compare_all();
        expect_eq("R2", "irq", irq, m_irq);
        expect_eq("R3", "bus_rdata", bus_rdata, m_rdata);
        expect_eq("R6", "out_data", out_data, m_out);
        expect_eq("R6", "out_valid", out_valid, m_valid);
        expect_eq("R8", "cpu_pc", cpu_pc, m_pc);
        expect_eq("R8", "cpu_in_isr", cpu_in_isr, m_isr);
    endtask

    task automatic cyc(bit s, bit w, int a, int d, bit e, int x, bit st, bit rt);
        bus_sel = s; bus_we = w; bus_addr = a[15:0]; bus_wdata = d[7:0];
        ext_stb = e; ext_data = x[7:0]; cpu_step = st; cpu_ret = rt;
        @(posedge clk);
        model_update();
        @(negedge clk);
        bus_sel = 0; bus_we = 0; ext_stb = 0; cpu_step = 0; cpu_ret = 0;
        compare_all();
    endtask

    task automatic idle();          cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic arrive(int x);   cyc(0, 0, 0, 0, 1, x, 0, 0); endtask
    task automatic rd(int a);       cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
    task automatic wr(int a, int d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        expect_eq("R1", "irq", irq, 0);
        expect_eq("R1", "bus_rdata", bus_rdata, 0);
        expect_eq("R1", "out_data", out_data, 0);
        expect_eq("R1", "out_valid", out_valid, 0);
        expect_eq("R1", "cpu_pc", cpu_pc, 100);
        expect_eq("R1", "cpu_in_isr", cpu_in_isr, 0);
        idle();

        // R2 arrival
        arrive(8'h5A);
        expect_eq("R2", "irq after arrival", irq, 1);
        // R4 read meets arrival
        cyc(1, 0, IN_A, 0, 1, 8'h77, 0, 0);
        expect_eq("R4", "irq kept", irq, 1);
        expect_eq("R4", "older byte", bus_rdata, 8'h5A);
        // R5 overrun
        arrive(8'h88);
        rd(ST_A);
        expect_eq("R5", "status overrun+irq", bus_rdata, 8'h03);
        rd(ST_A);
        expect_eq("R5", "status after clear", bus_rdata, 8'h02);
        // R3 read clears
        rd(IN_A);
        expect_eq("R3", "newest byte", bus_rdata, 8'h88);
        expect_eq("R3", "irq cleared", irq, 0);
        idle();
        expect_eq("R7", "rdata idle zero", bus_rdata, 0);

        // R6 output path
        wr(OUT_A, 8'hC3);
        expect_eq("R6", "out_data", out_data, 8'hC3);
        expect_eq("R6", "out_valid pulse", out_valid, 1);
        idle();
        expect_eq("R6", "out_valid single", out_valid, 0);
        rd(OUT_A);
        expect_eq("R6", "out readback", bus_rdata, 8'hC3);

        // R7 ignored accesses
        wr(IN_A, 8'h11);
        rd(IN_A);
        expect_eq("R7", "input untouched", bus_rdata, 8'h88);
        wr(ST_A, 8'hFF);
        rd(ST_A);
        expect_eq("R7", "status untouched", bus_rdata, 0);
        rd(NONE_A);
        expect_eq("R7", "unmapped read", bus_rdata, 0);
        wr(16'h8003, 8'h44);
        expect_eq("R7", "out unchanged", out_data, 8'hC3);
        expect_eq("R7", "no pulse", out_valid, 0);

        // R8/R9 fixed vector flow
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_eq("R8", "plain step", cpu_pc, 101);
        arrive(8'h21);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_eq("R8", "vector", cpu_pc, 16);
        expect_eq("R8", "in handler", cpu_in_isr, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_eq("R8", "no reentry", cpu_pc, 17);
        rd(IN_A);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        expect_eq("R9", "resume", cpu_pc, 102);
        expect_eq("R9", "left handler", cpu_in_isr, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        expect_eq("R9", "stray return", cpu_pc, 102);
        arrive(8'h22);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        expect_eq("R9", "return beats step", cpu_pc, 103);
        rd(IN_A);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int pick, a;
            pick = $urandom % 4;
            a = (pick == 0) ? IN_A : (pick == 1) ? OUT_A : (pick == 2) ? ST_A : NONE_A;
            cyc(($urandom % 3) == 0, $urandom % 2, a, $urandom % 256,
                ($urandom % 4) == 0, $urandom % 256,
                ($urandom % 2) == 0, ($urandom % 6) == 0);
        end
        finish_run();
    end
endmodule